// File: doc/BRIEF.md
# Frequency-Locked Loop Filter Sequencer

This block is the digital loop filter and mode sequencer of a two-stage frequency-locked loop. It turns raw frequency-detector requests into a 7-bit control code for an oscillator DAC. After reset it is in a coarse acquisition mode, where every up request raises the code by one DAC step. Once the coarse detector reports lock, it moves to a fine tracking mode. In that mode separate up and down pulses move the accumulator by 1/128 of the coarse step. The detector gain stays the same in both modes, and only the step shifter sets the loop gain.

The requests are summed in an 18-bit saturating accumulator. The four lowest accumulator bits are discarded. Of the 14 bits that remain, the upper 7 form an integer code and the lower 7 a fraction. A first-order delta-sigma modulator dithers the integer code by one step so that, on average over time, the output carries the fraction. The fine tracking mode has two named states: FINE_ACQUIRE and FINE_LOCKED. The sequencer reports which state it is in, and it keeps applying fine corrections while locked.

States: COARSE (after reset), FINE_ACQUIRE, FINE_LOCKED. Transitions: COARSE to FINE_ACQUIRE on coarse lock; FINE_ACQUIRE to FINE_LOCKED on fine lock; FINE_LOCKED back to FINE_ACQUIRE when fine lock drops. Only a reset returns the block to COARSE.

Top module: `freq_loop_filter_seq`

## Requirements
- R1: While reset is active and on the first cycle after it is released, mode_o is 0 (COARSE), fine_locked_o is 0, dac_code_o is 0, and the accumulator holds its minimum value 0.
- R2: In COARSE, each clock edge with coarse_up_i high adds 2048 to the accumulator, which is one DAC code step. The accumulator never decreases in this mode, and fine_up_i, fine_dn_i and fine_lock_i have no effect on it.
- R3: COARSE moves to FINE_ACQUIRE (mode_o = 1) on the edge where coarse_lock_i is high. From then on coarse_up_i and coarse_lock_i are ignored, and only reset returns the block to COARSE.
- R4: In FINE_ACQUIRE and FINE_LOCKED, an edge with only fine_up_i high adds 16 (1/128 of the coarse step), an edge with only fine_dn_i high subtracts 16, and an edge with both or neither high leaves the accumulator unchanged.
- R5: FINE_ACQUIRE moves to FINE_LOCKED (mode_o = 2, fine_locked_o = 1) on an edge with fine_lock_i high, and FINE_LOCKED returns to FINE_ACQUIRE on an edge with fine_lock_i low. Fine steps continue to apply in FINE_LOCKED.
- R6: The accumulator saturates at 262143 and at 0 and never wraps.
- R7: Accumulator bits [3:0] are discarded. Bits [17:11] form the integer code and bits [10:4] the 7-bit modulator fraction.
- R8: The modulator keeps a 7-bit error register and adds the fraction to it on every edge; the carry out is added to the integer code. dac_code_o is registered and reflects the accumulator value from one edge earlier. With the accumulator held constant, in any 128 consecutive cycles dac_code_o equals integer+1 exactly as many times as the value of the fraction.
- R9: When the integer code plus the carry would exceed 127, dac_code_o stays at 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_up_i | input | 1 | Coarse detector up request |
| coarse_lock_i | input | 1 | Coarse detector lock report |
| fine_up_i | input | 1 | Fine detector up pulse |
| fine_dn_i | input | 1 | Fine detector down pulse |
| fine_lock_i | input | 1 | Fine detector lock report |
| dac_code_o | output | 7 | Modulated oscillator DAC code |
| mode_o | output | 2 | 0 COARSE, 1 FINE_ACQUIRE, 2 FINE_LOCKED |
| fine_locked_o | output | 1 | High in FINE_LOCKED |

## Verification
The hardest conditions to reach from the ports are the two saturation limits and the long-run duty of the modulator carry, because the accumulator can only be moved in whole steps. To reach the top limit, the stimulus holds the coarse request high for more than 128 edges and then pushes further with fine up pulses. The bottom limit is reached by entering fine mode straight after reset and sending down pulses. To check the dither duty, a chosen number of fine up pulses places a known fraction in bits [10:4]. The stimulus then holds the inputs for 128 cycles and counts how often the code sits one step above the integer part.

// File: rtl/fll_seq_pkg.sv
`timescale 1ns/1ps
package fll_seq_pkg;
    typedef enum logic [1:0] {
        FS_COARSE = 2'd0,
        FS_FINE   = 2'd1,
        FS_LOCKED = 2'd2
    } fll_state_e;
endpackage

// File: rtl/fll_mode_ctrl.sv
`timescale 1ns/1ps
module fll_mode_ctrl
    import fll_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       coarse_lock_i,
    input  logic       fine_lock_i,
    output fll_state_e state_o,
    output logic       coarse_active_o,
    output logic       fine_locked_o
);
    fll_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_COARSE: if (coarse_lock_i) state_d = FS_FINE;
            FS_FINE:   if (fine_lock_i)   state_d = FS_LOCKED;
            FS_LOCKED: if (!fine_lock_i)  state_d = FS_FINE;
            default:                      state_d = FS_COARSE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_COARSE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        coarse_active_o = 1'b0;
        fine_locked_o   = 1'b0;
        unique case (state_q)
            FS_COARSE: coarse_active_o = 1'b1;
            FS_FINE:   coarse_active_o = 1'b0;
            FS_LOCKED: fine_locked_o   = 1'b1;
            default:   coarse_active_o = 1'b1;
        endcase
    end
    assign state_o = state_q;

    AST_NO_RETURN_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FS_COARSE) |=> (state_q != FS_COARSE)); // R3
    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_FINE && fine_lock_i) |=> (state_q == FS_LOCKED)); // R5
    AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_LOCKED && !fine_lock_i) |=> (state_q == FS_FINE)); // R5
endmodule

// File: rtl/fll_step_accum.sv
`timescale 1ns/1ps
module fll_step_accum #(
    parameter int ACC_W       = 18,
    parameter int DROP_W      = 4,
    parameter int COARSE_STEP = 2048,
    parameter int FINE_SHIFT  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    coarse_active_i,
    input  logic                    coarse_up_i,
    input  logic                    fine_up_i,
    input  logic                    fine_dn_i,
    output logic [ACC_W-DROP_W-1:0] word_o
);
    localparam logic [ACC_W:0] C_STEP  = (ACC_W+1)'(COARSE_STEP);
    localparam logic [ACC_W:0] F_STEP  = (ACC_W+1)'(COARSE_STEP >> FINE_SHIFT);
    localparam logic [ACC_W:0] ACC_MAX = {1'b0, {ACC_W{1'b1}}};

    logic [ACC_W-1:0] acc_q, acc_d;
    logic [ACC_W:0]   ext, up_sum, dn_diff, step;
    logic             inc, dec;

    always_comb begin
        ext     = {1'b0, acc_q};
        step    = coarse_active_i ? C_STEP : F_STEP;
        up_sum  = ext + step;
        dn_diff = ext - F_STEP;
        inc     = coarse_active_i ? coarse_up_i : (fine_up_i & ~fine_dn_i);
        dec     = ~coarse_active_i & fine_dn_i & ~fine_up_i;
        acc_d   = acc_q;
        if (inc) begin
            if (up_sum > ACC_MAX) acc_d = {ACC_W{1'b1}};
            else                  acc_d = up_sum[ACC_W-1:0];
        end else if (dec) begin
            if (ext < F_STEP)     acc_d = '0;
            else                  acc_d = dn_diff[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign word_o = acc_q[ACC_W-1:DROP_W];

    AST_COARSE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_active_i |=> (acc_q >= $past(acc_q))); // R2
    AST_FINE_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        !coarse_active_i |=> ((acc_q == $past(acc_q)) ||
                              ({1'b0, acc_q} == {1'b0, $past(acc_q)} + F_STEP) ||
                              ({1'b0, acc_q} + F_STEP == {1'b0, $past(acc_q)}) ||
                              (acc_q == '0) || (acc_q == {ACC_W{1'b1}}))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_active_i && coarse_up_i && acc_q == {ACC_W{1'b1}}) |=> (acc_q == {ACC_W{1'b1}})); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!coarse_active_i && fine_dn_i && !fine_up_i && acc_q == '0) |=> (acc_q == '0)); // R6
endmodule

// File: rtl/fll_dsm.sv
`timescale 1ns/1ps
module fll_dsm #(
    parameter int ACC_W  = 18,
    parameter int DROP_W = 4,
    parameter int DAC_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-DROP_W-1:0] word_i,
    output logic [DAC_W-1:0]        dac_o
);
    localparam int TRUNC_W = ACC_W - DROP_W;
    localparam int FRAC_W  = TRUNC_W - DAC_W;

    logic [DAC_W-1:0] int_part, dac_q, dac_d;
    logic             carry;

    assign int_part = word_i[TRUNC_W-1:FRAC_W];

    generate
        if (FRAC_W > 0) begin : g_mod
            logic [FRAC_W-1:0] err_q;
            logic [FRAC_W:0]   sum;
            assign sum   = {1'b0, err_q} + {1'b0, word_i[FRAC_W-1:0]};
            assign carry = sum[FRAC_W];
            always_ff @(posedge clk) begin
                if (!rst_n) err_q <= '0;
                else        err_q <= sum[FRAC_W-1:0];
            end
        end else begin : g_direct
            assign carry = 1'b0;
        end
    endgenerate

    always_comb begin
        if (carry && int_part == {DAC_W{1'b1}}) dac_d = int_part;
        else                                     dac_d = int_part + DAC_W'(carry);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dac_q <= '0;
        else        dac_q <= dac_d;
    end
    assign dac_o = dac_q;

    AST_DAC_TRACKS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dac_q == $past(int_part)) || (dac_q == $past(int_part) + 1'b1))); // R8
    AST_DAC_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_part == {DAC_W{1'b1}}) |=> (dac_q == {DAC_W{1'b1}})); // R9
endmodule

// File: rtl/freq_loop_filter_seq.sv
`timescale 1ns/1ps
module freq_loop_filter_seq
    import fll_seq_pkg::*;
#(
    parameter int ACC_W       = 18,
    parameter int DROP_W      = 4,
    parameter int DAC_W       = 7,
    parameter int FINE_SHIFT  = 7,
    parameter int COARSE_STEP = 1 << (ACC_W - DAC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coarse_up_i,
    input  logic             coarse_lock_i,
    input  logic             fine_up_i,
    input  logic             fine_dn_i,
    input  logic             fine_lock_i,
    output logic [DAC_W-1:0] dac_code_o,
    output logic [1:0]       mode_o,
    output logic             fine_locked_o
);
    localparam int TRUNC_W = ACC_W - DROP_W;

    fll_state_e         state;
    logic               coarse_active;
    logic [TRUNC_W-1:0] word;

    fll_mode_ctrl u_mode (
        .clk             (clk),
        .rst_n           (rst_n),
        .coarse_lock_i   (coarse_lock_i),
        .fine_lock_i     (fine_lock_i),
        .state_o         (state),
        .coarse_active_o (coarse_active),
        .fine_locked_o   (fine_locked_o)
    );

    fll_step_accum #(
        .ACC_W       (ACC_W),
        .DROP_W      (DROP_W),
        .COARSE_STEP (COARSE_STEP),
        .FINE_SHIFT  (FINE_SHIFT)
    ) u_accum (
        .clk             (clk),
        .rst_n           (rst_n),
        .coarse_active_i (coarse_active),
        .coarse_up_i     (coarse_up_i),
        .fine_up_i       (fine_up_i),
        .fine_dn_i       (fine_dn_i),
        .word_o          (word)
    );

    fll_dsm #(
        .ACC_W  (ACC_W),
        .DROP_W (DROP_W),
        .DAC_W  (DAC_W)
    ) u_dsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (word),
        .dac_o  (dac_code_o)
    );

    assign mode_o = state;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 2'd0 && dac_code_o == '0 && !fine_locked_o)); // R1
endmodule

// File: tb/freq_loop_filter_seq_bench.sv
`timescale 1ns/1ps
module freq_loop_filter_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cu = 1'b0, cl = 1'b0, fu = 1'b0, fd = 1'b0, fl = 1'b0;
    logic [6:0] dac;
    logic [1:0] mode;
    logic       flk;

    int n_chk = 0, n_fail = 0;
    int m_state = 0, m_acc = 0, m_err = 0, m_dac = 0;

    always #2.5 clk = ~clk;

    freq_loop_filter_seq u_freq_loop_filter_seq (
        .clk(clk), .rst_n(rst_n), .coarse_up_i(cu), .coarse_lock_i(cl),
        .fine_up_i(fu), .fine_dn_i(fd), .fine_lock_i(fl),
        .dac_code_o(dac), .mode_o(mode), .fine_locked_o(flk));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R3 R5 mode", int'(mode), m_state);
        chk("R5 fine_locked", int'(flk), (m_state == 2) ? 1 : 0);
        chk("R2 R4 R6 R7 R8 R9 dac", int'(dac), m_dac);
    endtask

    // one clock with given inputs; model advances from pre-edge values
    task automatic cyc(input logic a_cu, input logic a_cl, input logic a_fu,
                       input logic a_fd, input logic a_fl);
        int ip, fr, s, nacc, nstate;
        cu = a_cu; cl = a_cl; fu = a_fu; fd = a_fd; fl = a_fl;
        @(posedge clk);
        ip = m_acc >> 11;
        fr = (m_acc >> 4) & 127;
        s  = m_err + fr;
        nacc = m_acc;
        if (m_state == 0) begin
            if (a_cu) nacc = (m_acc + 2048 > 262143) ? 262143 : m_acc + 2048;
        end else if (a_fu && !a_fd) begin
            nacc = (m_acc + 16 > 262143) ? 262143 : m_acc + 16;
        end else if (a_fd && !a_fu) begin
            nacc = (m_acc < 16) ? 0 : m_acc - 16;
        end
        nstate = m_state;
        if (m_state == 0 && a_cl) nstate = 1;
        else if (m_state == 1 && a_fl) nstate = 2;
        else if (m_state == 2 && !a_fl) nstate = 1;
        m_dac = (ip + s / 128 > 127) ? 127 : ip + s / 128;
        m_err = s % 128;
        m_acc = nacc;
        m_state = nstate;
        #1;
        check_all();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cu = 0; cl = 0; fu = 0; fd = 0; fl = 0;
        repeat (3) @(negedge clk);
        m_state = 0; m_acc = 0; m_err = 0; m_dac = 0;
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset dac", int'(dac), 0);
        chk("R1 reset fine_locked", int'(flk), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        @(negedge clk);
        do_reset();
        // R2: coarse ramp, fine inputs toggled and ignored
        for (int i = 0; i < 60; i++)
            cyc(i % 3 != 0, 1'b0, i % 2 == 1, i % 5 == 0, i % 7 == 0);
        // R3: switch to fine, then coarse inputs ignored
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 700; i++)
            cyc(1'b1, i % 2 == 1, i % 3 != 0, i % 5 == 0, 1'b0);
        for (int i = 0; i < 300; i++)
            cyc(1'b0, 1'b0, i % 4 == 0, i % 3 == 0, 1'b0);
        // R5: lock, keep tracking, unlock, relock
        for (int i = 0; i < 50; i++) cyc(1'b0, 1'b0, i % 2 == 0, 1'b0, 1'b1);
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);

        // R6 R9: top saturation
        do_reset();
        for (int i = 0; i < 140; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 dac at top", int'(dac), 127);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

        // R6: bottom saturation
        do_reset();
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 dac at bottom", int'(dac), 0);
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R7 R8: carry duty equals fraction
        do_reset();
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 37; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        cnt = 0;
        for (int i = 0; i < 128; i++) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            if (dac == 7'd1) cnt++;
        end
        chk("R8 carry count frac 37", cnt, 37);
        for (int i = 0; i < 63 + 128; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        cnt = 0;
        for (int i = 0; i < 128; i++) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            if (dac == 7'd2) cnt++;
        end
        chk("R7 R8 carry count int 1 frac 100", cnt, 100);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule